// File: doc/BRIEF.md
# Floating-Point Exception Status Recorder

This block takes the exception flags that a floating-point operation reports and writes them into the floating-point status word. The caller presents a 5-bit exception vector, the current status word and the current program-counter pair, all qualified by one valid strobe. One clock later the block returns three things: the updated status word, the updated program-counter pair, and a one-cycle trap request.

Whether a trap is taken depends on the trap-enable field of the incoming status word. On a trap, the enabled exceptions are reduced to a single flag by a fixed priority. That flag goes into the current-exception field, the trap-type bit is set, the accrued field is left alone and the program-counter pair is held. Without a trap, the whole vector is written into the current field and ORed into the accrued field, and the program-counter pair steps forward by one instruction.

Internally, a three-state machine records the outcome of the last strobe:
- `ST_IDLE`: no strobe in the previous cycle.
- `ST_ADVANCE`: a strobe that did not trap.
- `ST_TRAP`: a strobe that trapped.

From any state, the next state is chosen every cycle. No strobe leads to `ST_IDLE`. A strobe without trap leads to `ST_ADVANCE`. A strobe with trap leads to `ST_TRAP`. Reset forces `ST_IDLE`. The trap request is high exactly in `ST_TRAP`.

Top module: `fp_exc_recorder`

## Requirements
- R1: A synchronous active-low reset clears the status word output, both program-counter outputs and the trap request to zero.
- R2: One cycle after a strobe, trap_req is 1 exactly when the exception vector and the trap-enable field (status bits 27:23) share a set bit. Otherwise it is 0.
- R3: On a trap, the current-exception field (status bits 4:0) holds exactly one bit. That bit is the highest-priority bit of the vector masked by the enable field. Priority, highest first, uses this encoding: bit 4 invalid, bit 3 overflow, bit 2 underflow, bit 1 divide-by-zero, bit 0 inexact.
- R4: Without a trap, the current-exception field equals the reported vector. The accrued field (status bits 9:5) equals its incoming value ORed with that vector.
- R5: On a trap, the accrued field keeps its incoming value.
- R6: On a trap, status bit 14 is set. Every status bit outside the current and accrued fields otherwise copies the incoming status word, with or without a trap.
- R7: Without a trap, pc_out takes npc_in and npc_out takes npc_in + 4, wrapping modulo 2^PC_W.
- R8: On a trap, pc_out and npc_out take pc_in and npc_in unchanged.
- R9: A strobe with an all-zero vector clears the current field, leaves the accrued field unchanged and advances the program-counter pair.
- R10: In a cycle without a strobe, the outputs hold their values and trap_req is 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| exc_valid | input | 1 | Strobe qualifying the other inputs |
| exc_vec | input | 5 | Reported exception flags |
| fsr_in | input | FSR_W (32) | Status word before the update |
| pc_in | input | PC_W (32) | Program counter of the operation |
| npc_in | input | PC_W (32) | Next program counter |
| fsr_out | output | FSR_W (32) | Updated status word |
| pc_out | output | PC_W (32) | Updated program counter |
| npc_out | output | PC_W (32) | Updated next program counter |
| trap_req | output | 1 | One-cycle trap request |

## Verification
The FSM state drives trap_req directly. A wrong state therefore shows as a missing or extra trap request in the first cycle after the strobe, and the program-counter pair goes wrong in that same cycle. A wrong priority decision shows at once as a multi-bit or wrong single bit in the current field. A wrong trap decision shows as an accrued field that grew when it should have been frozen. Hold behaviour is checked by changing the inputs with the strobe low and observing several cycles.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
    localparam int EXC_W = 5;

    typedef logic [EXC_W-1:0] exc_t;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ADVANCE = 2'd1,
        ST_TRAP    = 2'd2
    } rec_state_t;
endpackage

// File: rtl/fpx_trap_decide.sv
module fpx_trap_decide #(
    parameter int EXC_W = 5
) (
    input  logic [EXC_W-1:0] exc,
    input  logic [EXC_W-1:0] enable,
    output logic             take_trap,
    output logic [EXC_W-1:0] exc_rec
);
    logic [EXC_W-1:0] armed;
    logic [EXC_W-1:0] above;
    logic [EXC_W-1:0] pick;

    assign armed     = exc & enable;
    assign take_trap = |armed;

    // Highest index wins: a bit is kept only when no higher enabled bit is set.
    generate
        for (genvar i = EXC_W - 1; i >= 0; i--) begin : g_prio
            if (i == EXC_W - 1) begin : g_top
                assign above[i] = 1'b0;
            end else begin : g_rest
                assign above[i] = above[i+1] | armed[i+1];
            end
            assign pick[i] = armed[i] & ~above[i];
        end
    endgenerate

    assign exc_rec = take_trap ? pick : exc;
endmodule

// File: rtl/fpx_status_merge.sv
module fpx_status_merge #(
    parameter int FSR_W    = 32,
    parameter int EXC_W    = 5,
    parameter int TEM_LSB  = 23,
    parameter int AEXC_LSB = 5,
    parameter int CEXC_LSB = 0,
    parameter int TT_BIT   = 14
) (
    input  logic [FSR_W-1:0] fsr_in,
    input  logic [EXC_W-1:0] exc_rec,
    input  logic             take_trap,
    output logic [EXC_W-1:0] enable,
    output logic [FSR_W-1:0] fsr_next
);
    assign enable = fsr_in[TEM_LSB +: EXC_W];

    always_comb begin
        fsr_next = fsr_in;
        fsr_next[CEXC_LSB +: EXC_W] = exc_rec;
        if (take_trap) begin
            fsr_next[TT_BIT] = 1'b1;
        end else begin
            fsr_next[AEXC_LSB +: EXC_W] = fsr_in[AEXC_LSB +: EXC_W] | exc_rec;
        end
    end
endmodule

// File: rtl/fpx_pc_step.sv
module fpx_pc_step #(
    parameter int PC_W    = 32,
    parameter int PC_STEP = 4
) (
    input  logic [PC_W-1:0] pc_in,
    input  logic [PC_W-1:0] npc_in,
    input  logic            hold,
    output logic [PC_W-1:0] pc_nx,
    output logic [PC_W-1:0] npc_nx
);
    localparam logic [PC_W-1:0] STEP = PC_W'(PC_STEP);

    assign pc_nx  = hold ? pc_in  : npc_in;
    assign npc_nx = hold ? npc_in : npc_in + STEP;
endmodule

// File: rtl/fp_exc_recorder.sv
module fp_exc_recorder #(
    parameter int FSR_W    = 32,
    parameter int PC_W     = 32,
    parameter int TEM_LSB  = 23,
    parameter int AEXC_LSB = 5,
    parameter int CEXC_LSB = 0,
    parameter int TT_BIT   = 14,
    parameter int PC_STEP  = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      exc_valid,
    input  logic [fpx_pkg::EXC_W-1:0] exc_vec,
    input  logic [FSR_W-1:0]          fsr_in,
    input  logic [PC_W-1:0]           pc_in,
    input  logic [PC_W-1:0]           npc_in,
    output logic [FSR_W-1:0]          fsr_out,
    output logic [PC_W-1:0]           pc_out,
    output logic [PC_W-1:0]           npc_out,
    output logic                      trap_req
);
    import fpx_pkg::*;

    rec_state_t       state, state_nx;
    exc_t             enable;
    exc_t             exc_rec;
    logic             take_trap;
    logic [FSR_W-1:0] fsr_nx;
    logic [PC_W-1:0]  pc_nx, npc_nx;

    fpx_status_merge #(
        .FSR_W(FSR_W), .EXC_W(EXC_W), .TEM_LSB(TEM_LSB),
        .AEXC_LSB(AEXC_LSB), .CEXC_LSB(CEXC_LSB), .TT_BIT(TT_BIT)
    ) u_merge (
        .fsr_in(fsr_in), .exc_rec(exc_rec), .take_trap(take_trap),
        .enable(enable), .fsr_next(fsr_nx)
    );

    fpx_trap_decide #(.EXC_W(EXC_W)) u_decide (
        .exc(exc_vec), .enable(enable),
        .take_trap(take_trap), .exc_rec(exc_rec)
    );

    fpx_pc_step #(.PC_W(PC_W), .PC_STEP(PC_STEP)) u_pc (
        .pc_in(pc_in), .npc_in(npc_in), .hold(take_trap),
        .pc_nx(pc_nx), .npc_nx(npc_nx)
    );

    always_comb begin
        unique case ({exc_valid, take_trap})
            2'b10:   state_nx = ST_ADVANCE;
            2'b11:   state_nx = ST_TRAP;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsr_out <= '0;
            pc_out  <= '0;
            npc_out <= '0;
        end else if (exc_valid) begin
            fsr_out <= fsr_nx;
            pc_out  <= pc_nx;
            npc_out <= npc_nx;
        end
    end

    assign trap_req = (state == ST_TRAP);
endmodule

// File: rtl/fpx_checker.sv
module fpx_checker #(
    parameter int FSR_W    = 32,
    parameter int PC_W     = 32,
    parameter int TEM_LSB  = 23,
    parameter int AEXC_LSB = 5,
    parameter int CEXC_LSB = 0,
    parameter int TT_BIT   = 14,
    parameter int PC_STEP  = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             exc_valid,
    input logic [4:0]       exc_vec,
    input logic [FSR_W-1:0] fsr_in,
    input logic [PC_W-1:0]  pc_in,
    input logic [PC_W-1:0]  npc_in,
    input logic [FSR_W-1:0] fsr_out,
    input logic [PC_W-1:0]  pc_out,
    input logic [PC_W-1:0]  npc_out,
    input logic             trap_req
);
    AST_TRAP_DECISION: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |=> (trap_req == ($past((exc_vec & fsr_in[TEM_LSB +: 5]) != 5'd0)))); // R2
    AST_SINGLE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> ($countones(fsr_out[CEXC_LSB +: 5]) == 1)); // R3
    AST_ACCRUED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> (fsr_out[AEXC_LSB +: 5] == $past(fsr_in[AEXC_LSB +: 5]))); // R5
    AST_TRAP_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> fsr_out[TT_BIT]); // R6
    AST_PC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> (pc_out == $past(pc_in) && npc_out == $past(npc_in))); // R8
    AST_PC_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(exc_valid) && !trap_req) |-> (pc_out == $past(npc_in)
            && npc_out == $past(npc_in) + PC_W'(PC_STEP))); // R7
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !exc_valid |=> ($stable(fsr_out) && $stable(pc_out) && !trap_req)); // R10
endmodule

bind fp_exc_recorder fpx_checker #(
    .FSR_W(FSR_W), .PC_W(PC_W), .TEM_LSB(TEM_LSB), .AEXC_LSB(AEXC_LSB),
    .CEXC_LSB(CEXC_LSB), .TT_BIT(TT_BIT), .PC_STEP(PC_STEP)
) u_chk (
    .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exc_vec(exc_vec),
    .fsr_in(fsr_in), .pc_in(pc_in), .npc_in(npc_in), .fsr_out(fsr_out),
    .pc_out(pc_out), .npc_out(npc_out), .trap_req(trap_req)
);

// File: tb/fp_exc_recorder_test.sv
module fp_exc_recorder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exc_valid = 1'b0;
    logic [4:0]  exc_vec = '0;
    logic [31:0] fsr_in = '0, pc_in = '0, npc_in = '0;
    logic [31:0] fsr_out, pc_out, npc_out;
    logic        trap_req;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;  // 250 MHz

    fp_exc_recorder uut (
        .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exc_vec(exc_vec),
        .fsr_in(fsr_in), .pc_in(pc_in), .npc_in(npc_in),
        .fsr_out(fsr_out), .pc_out(pc_out), .npc_out(npc_out), .trap_req(trap_req)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic [4:0]  exc;
        logic [31:0] fsr;
        logic [31:0] pc;
        logic [31:0] npc;
        logic [31:0] e_fsr;
        logic [31:0] e_pc;
        logic [31:0] e_npc;
        logic        e_trap;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        // R9: no exceptions, current cleared, accrued kept, pair advances
        '{4'd9, 5'h00, 32'h0F80007F, 32'h100, 32'h104, 32'h0F800060, 32'h104, 32'h108, 1'b0},
        // R4: no enables, invalid+inexact recorded and accrued
        '{4'd4, 5'h11, 32'h00000020, 32'h100, 32'h104, 32'h00000231, 32'h104, 32'h108, 1'b0},
        // R3: invalid beats overflow and underflow
        '{4'd3, 5'h1C, 32'h0E000000, 32'h100, 32'h104, 32'h0E004010, 32'h100, 32'h104, 1'b1},
        // R5: only divide-by-zero enabled, accrued frozen
        '{4'd5, 5'h0A, 32'h01000080, 32'h200, 32'h204, 32'h01004082, 32'h200, 32'h204, 1'b1},
        // R2: exceptions disjoint from enables, no trap
        '{4'd2, 5'h05, 32'h0C00001F, 32'h300, 32'h304, 32'h0C0000A5, 32'h304, 32'h308, 1'b0},
        // R3: overflow beats underflow
        '{4'd3, 5'h0C, 32'h06000000, 32'h400, 32'h404, 32'h06004008, 32'h400, 32'h404, 1'b1},
        // R7: next-PC wraps
        '{4'd7, 5'h01, 32'h00000000, 32'hFFFFFFF8, 32'hFFFFFFFC, 32'h00000021, 32'hFFFFFFFC, 32'h0, 1'b0},
        // R6: trap keeps upper bits, sets bit 14
        '{4'd6, 5'h01, 32'h80804000, 32'h500, 32'h504, 32'h80804001, 32'h500, 32'h504, 1'b1},
        // R6: no trap copies other bits
        '{4'd6, 5'h02, 32'hF0001C00, 32'h600, 32'h604, 32'hF0001C42, 32'h604, 32'h608, 1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    initial begin : watchdog
        #400000;
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 fsr", fsr_out, 32'h0);
        chk("R1 pc", pc_out, 32'h0);
        chk("R1 npc", npc_out, 32'h0);
        chk("R1 trap", {31'd0, trap_req}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            exc_valid = 1'b1;
            exc_vec   = VECS[i].exc;
            fsr_in    = VECS[i].fsr;
            pc_in     = VECS[i].pc;
            npc_in    = VECS[i].npc;
            @(negedge clk);
            chk($sformatf("R%0d vec%0d fsr", VECS[i].req, i), fsr_out, VECS[i].e_fsr);
            chk($sformatf("R%0d vec%0d pc", VECS[i].req, i), pc_out, VECS[i].e_pc);
            chk($sformatf("R%0d vec%0d npc", VECS[i].req, i), npc_out, VECS[i].e_npc);
            chk($sformatf("R%0d vec%0d trap", VECS[i].req, i), {31'd0, trap_req}, {31'd0, VECS[i].e_trap});
        end

        // R10: strobe low, inputs change, outputs hold (last vector result)
        exc_valid = 1'b0;
        exc_vec   = 5'h1F;
        fsr_in    = 32'h0F800000;
        pc_in     = 32'hABC0;
        npc_in    = 32'hABC4;
        repeat (3) @(negedge clk);
        chk("R10 fsr", fsr_out, 32'hF0001C42);
        chk("R10 pc", pc_out, 32'h604);
        chk("R10 npc", npc_out, 32'h608);
        chk("R10 trap", {31'd0, trap_req}, 32'h0);

        // R2: trap request lasts one cycle after a trapping strobe
        exc_valid = 1'b1;
        @(negedge clk);
        chk("R2 trap pulse", {31'd0, trap_req}, 32'h1);
        chk("R3 invalid first", fsr_out, 32'h0F804010);
        exc_valid = 1'b0;
        @(negedge clk);
        chk("R2 trap drop", {31'd0, trap_req}, 32'h0);

        // R1: reset mid-run clears everything
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 fsr again", fsr_out, 32'h0);
        chk("R1 npc again", npc_out, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule